// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block makes the traps of an in-order integer pipeline (fetch, decode, execute, memory, write-back) precise. Each of the first four stages can report a fault for the instruction it holds. The block records that fault in a status vector that moves down the pipeline with the instruction. The vector holds one cause field per stage. Nothing acts on a recorded fault until the instruction reaches the commit point, which is the move from memory to write-back. As a result, a younger instruction that faults early can never get ahead of an older instruction that faults later.

When a faulting instruction commits, its memory write is blocked. The instruction is not allowed into write-back, and it is discarded together with every younger instruction. In the next cycle the block raises a one-cycle flush, presents the trap vector address as the new fetch target, and holds the faulting PC and a cause code for the handler. The instruction that is already in write-back is older than the faulting one, so it completes normally. The datapath uses the two write-permission outputs to gate its register-file and data-memory writes.

Top module: `xt_precise_tracker`

## Requirements
- R1: While reset is held, and after it is released, flush_o, rf_wr_ok_o, mem_wr_ok_o, redirect_pc_o, epc_o and cause_o are all zero.
- R2: With adv_i held high, a clean instruction that is presented in fetch in cycle n raises mem_wr_ok_o in cycle n+3. It raises rf_wr_ok_o, with retire_pc_o equal to its PC, in cycle n+4.
- R3: Every fault input is a 2-bit code in which 0 means no fault. Fetch uses 1 for a page fault, 2 for a misaligned fetch and 3 for a protection violation. Decode uses 1 for an undefined opcode and 2 for an illegal opcode. Execute uses 1 for an arithmetic fault. Memory uses 1 for a page fault, 2 for a misaligned access and 3 for a protection violation. A fault is recorded only when its stage holds a valid instruction. A fault on an empty stage has no effect.
- R4: A trap is taken only when a faulting instruction leaves the memory stage with adv_i high. In the next cycle, and for that cycle only, flush_o is high, epc_o holds the faulting PC, redirect_pc_o equals TRAP_VEC, and cause_o is {stage, code}. The stage numbers are fetch=0, decode=1, execute=2 and memory=3.
- R5: If an older instruction faults in a later stage in the same cycle that a younger instruction faults in an earlier stage, the older instruction's trap is taken.
- R6: If one instruction collects faults in several stages, cause_o reports the field of the earliest stage.
- R7: An instruction with any nonzero field in its status vector never raises mem_wr_ok_o and never retires.
- R8: The instructions younger than the faulting one never retire. An instruction presented in fetch during the flush cycle is also dropped.
- R9: The instruction in write-back when the trap is detected still retires in that cycle.
- R10: While adv_i is low, the pipeline holds, no trap is taken and mem_wr_ok_o is low.
- R11: epc_o, cause_o and redirect_pc_o keep their values until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Pipeline advances this cycle |
| if_valid_i | input | 1 | Fetch stage holds an instruction |
| if_pc_i | input | PCW | PC of the fetched instruction |
| if_fault_i | input | 2 | Fetch fault code |
| id_fault_i | input | 2 | Decode fault code |
| ex_fault_i | input | 2 | Execute fault code |
| mem_fault_i | input | 2 | Memory fault code |
| mem_wr_ok_o | output | 1 | Memory-stage write permitted |
| rf_wr_ok_o | output | 1 | Write-back instruction retires, register write permitted |
| retire_pc_o | output | PCW | PC of the write-back instruction |
| flush_o | output | 1 | One-cycle flush and fetch redirect |
| redirect_pc_o | output | PCW | Trap vector fetch target |
| epc_o | output | PCW | Saved faulting PC |
| cause_o | output | 4 | {stage, code} of the trap taken |

## Verification
The hardest case to reach from the ports is two faults raised in one cycle by two different instructions, with the older one in memory and the younger one in fetch. Only the older one may trap. The bench lines up its issue sequence so that the load reaches the memory stage in exactly the cycle the next instruction is being fetched, and it asserts both fault inputs in that cycle. It then checks the saved PC and cause, and checks that neither the younger instructions nor a wrong-path fetch during the flush ever retire.

// File: rtl/xt_pkg.sv
package xt_pkg;
  localparam int NFS = 4;               // stages able to raise a fault
  localparam int CW  = 2;               // cause code width per stage
  localparam int SW  = $clog2(NFS);     // stage index width
  localparam int CAUSE_W = SW + CW;

  typedef enum logic [SW-1:0] {
    STG_IF  = 2'd0,
    STG_ID  = 2'd1,
    STG_EX  = 2'd2,
    STG_MEM = 2'd3
  } stage_e;

  typedef logic [NFS-1:0][CW-1:0] svec_t;
endpackage

// File: rtl/xt_fault_merge.sv
module xt_fault_merge
  import xt_pkg::*;
#(
  parameter int STG = 0
) (
  input  logic          in_valid,
  input  svec_t         in_vec,
  input  logic [CW-1:0] fault,
  output svec_t         out_vec
);
  // A stage writes only its own field, and only for a valid instruction
  always_comb begin
    out_vec = in_vec;
    if (in_valid) begin
      out_vec[STG] = fault;
    end
  end
endmodule

// File: rtl/xt_stage_reg.sv
module xt_stage_reg
  import xt_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           kill,
  input  logic           in_valid,
  input  logic [PCW-1:0] in_pc,
  input  svec_t          in_vec,
  output logic           out_valid,
  output logic [PCW-1:0] out_pc,
  output svec_t          out_vec
);
  logic           v_q, v_n;
  logic [PCW-1:0] pc_q, pc_n;
  svec_t          vec_q, vec_n;
  logic           en;

  always_comb begin
    en    = load | kill;
    v_n   = 1'b0;
    pc_n  = pc_q;
    vec_n = '0;
    if (!kill) begin
      v_n   = in_valid;
      pc_n  = in_pc;
      vec_n = in_valid ? in_vec : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      pc_q  <= '0;
      vec_q <= '0;
    end else if (en) begin
      v_q   <= v_n;
      pc_q  <= pc_n;
      vec_q <= vec_n;
    end
  end

  assign out_valid = v_q;
  assign out_pc    = pc_q;
  assign out_vec   = vec_q;
endmodule

// File: rtl/xt_commit.sv
module xt_commit
  import xt_pkg::*;
#(
  parameter int             PCW      = 32,
  parameter logic [PCW-1:0] TRAP_VEC = 'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               mem_valid,
  input  logic [PCW-1:0]     mem_pc,
  input  svec_t              mem_vec,
  output logic               take_trap,
  output logic               mem_wr_ok,
  output logic               flush_o,
  output logic [PCW-1:0]     redirect_pc_o,
  output logic [PCW-1:0]     epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               any_fault;
  logic [SW-1:0]      sel;
  logic [CAUSE_W-1:0] cause_n, cause_q;
  logic [PCW-1:0]     epc_n, epc_q, rdr_n, rdr_q;
  logic               flush_n, flush_q;

  // Earliest stage wins: scan from the last stage down to the first
  always_comb begin
    any_fault = 1'b0;
    sel       = '0;
    for (int i = NFS - 1; i >= 0; i--) begin
      if (mem_vec[i] != '0) begin
        any_fault = 1'b1;
        sel       = SW'(i);
      end
    end
  end

  always_comb begin
    take_trap = adv & mem_valid & any_fault;
    mem_wr_ok = adv & mem_valid & ~any_fault;
    flush_n   = take_trap;
    cause_n   = cause_q;
    epc_n     = epc_q;
    rdr_n     = rdr_q;
    if (take_trap) begin
      cause_n = {sel, mem_vec[sel]};
      epc_n   = mem_pc;
      rdr_n   = TRAP_VEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      cause_q <= '0;
      epc_q   <= '0;
      rdr_q   <= '0;
    end else begin
      flush_q <= flush_n;
      if (take_trap) begin
        cause_q <= cause_n;
        epc_q   <= epc_n;
        rdr_q   <= rdr_n;
      end
    end
  end

  assign flush_o       = flush_q;
  assign cause_o       = cause_q;
  assign epc_o         = epc_q;
  assign redirect_pc_o = rdr_q;

  // R4
  flush_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);
  // R4
  flush_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> redirect_pc_o == TRAP_VEC);
  // R10
  stall_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !flush_o);
endmodule

// File: rtl/xt_precise_tracker.sv
module xt_precise_tracker
  import xt_pkg::*;
#(
  parameter int             PCW      = 32,
  parameter logic [PCW-1:0] TRAP_VEC = 'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic               if_valid_i,
  input  logic [PCW-1:0]     if_pc_i,
  input  logic [CW-1:0]      if_fault_i,
  input  logic [CW-1:0]      id_fault_i,
  input  logic [CW-1:0]      ex_fault_i,
  input  logic [CW-1:0]      mem_fault_i,
  output logic               mem_wr_ok_o,
  output logic               rf_wr_ok_o,
  output logic [PCW-1:0]     retire_pc_o,
  output logic               flush_o,
  output logic [PCW-1:0]     redirect_pc_o,
  output logic [PCW-1:0]     epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int NST = NFS + 1;   // fetch plus four latched stages

  // index 0 = fetch (combinational), 1..4 = decode, execute, memory, write-back
  logic           st_valid [NST];
  logic [PCW-1:0] st_pc    [NST];
  svec_t          st_vec   [NST];
  svec_t          mg_vec   [NFS];
  logic [CW-1:0]  flt      [NFS];
  logic           take_trap;

  assign flt[0] = if_fault_i;
  assign flt[1] = id_fault_i;
  assign flt[2] = ex_fault_i;
  assign flt[3] = mem_fault_i;

  assign st_valid[0] = if_valid_i;
  assign st_pc[0]    = if_pc_i;
  assign st_vec[0]   = '0;

  genvar g;
  generate
    for (g = 0; g < NFS; g++) begin : g_merge
      xt_fault_merge #(.STG(g)) u_merge (
        .in_valid (st_valid[g]),
        .in_vec   (st_vec[g]),
        .fault    (flt[g]),
        .out_vec  (mg_vec[g])
      );
    end

    for (g = 1; g < NST; g++) begin : g_stage
      logic kill_g;
      if (g == 1) begin : g_first
        // the wrong-path fetch in the flush cycle is dropped
        assign kill_g = take_trap | flush_o;
      end else begin : g_rest
        assign kill_g = take_trap;
      end
      xt_stage_reg #(.PCW(PCW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (adv_i),
        .kill      (kill_g),
        .in_valid  (st_valid[g-1]),
        .in_pc     (st_pc[g-1]),
        .in_vec    (mg_vec[g-1]),
        .out_valid (st_valid[g]),
        .out_pc    (st_pc[g]),
        .out_vec   (st_vec[g])
      );
    end
  endgenerate

  xt_commit #(.PCW(PCW), .TRAP_VEC(TRAP_VEC)) u_commit (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv           (adv_i),
    .mem_valid     (st_valid[NFS-1]),
    .mem_pc        (st_pc[NFS-1]),
    .mem_vec       (mg_vec[NFS-1]),
    .take_trap     (take_trap),
    .mem_wr_ok     (mem_wr_ok_o),
    .flush_o       (flush_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .cause_o       (cause_o)
  );

  assign rf_wr_ok_o  = st_valid[NST-1];
  assign retire_pc_o = st_pc[NST-1];

  // R7
  retire_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_ok_o |-> st_vec[NST-1] == '0);
  // R8
  flush_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !rf_wr_ok_o);
  // R7
  clean_store_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ok_o |=> !flush_o);
endmodule

// File: tb/tb_xt_precise_tracker.sv
`timescale 1ns/1ps
module tb_xt_precise_tracker;
  localparam logic [31:0] TV = 32'h80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv, ifv;
  logic [31:0] ifpc;
  logic [1:0]  fi, fd, fe, fm;
  logic        mem_wr_ok, rf_wr_ok, flush;
  logic [31:0] retire_pc, rdr, epc;
  logic [3:0]  cause;
  int          nchk = 0;
  int          nerr = 0;

  always #4 clk = ~clk;

  xt_precise_tracker #(.PCW(32), .TRAP_VEC(TV)) dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .if_valid_i(ifv), .if_pc_i(ifpc),
    .if_fault_i(fi), .id_fault_i(fd), .ex_fault_i(fe), .mem_fault_i(fm),
    .mem_wr_ok_o(mem_wr_ok), .rf_wr_ok_o(rf_wr_ok), .retire_pc_o(retire_pc),
    .flush_o(flush), .redirect_pc_o(rdr), .epc_o(epc), .cause_o(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] pc, input logic [1:0] a_if,
                     input logic [1:0] a_id, input logic [1:0] a_ex,
                     input logic [1:0] a_mem, input logic a_adv);
    @(negedge clk);
    adv = a_adv; ifv = v; ifpc = pc;
    fi = a_if; fd = a_id; fe = a_ex; fm = a_mem;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset;
    chk("R1 flush", flush, 0);
    chk("R1 rf_wr_ok", rf_wr_ok, 0);
    chk("R1 mem_wr_ok", mem_wr_ok, 0);
    chk("R1 epc", epc, 0);
    chk("R1 cause", cause, 0);
    chk("R1 redirect", rdr, 0);
  endtask

  task automatic t_flow;
    cyc(1, 32'h100, 0, 0, 0, 0, 1);
    cyc(1, 32'h104, 0, 0, 0, 0, 1);
    cyc(1, 32'h108, 0, 0, 0, 0, 1);
    cyc(1, 32'h10C, 0, 0, 0, 0, 1);
    chk("R2 mem_wr_ok n+3", mem_wr_ok, 1);
    idle(1);
    chk("R2 retire n+4", rf_wr_ok, 1);
    chk("R2 retire pc", retire_pc, 32'h100);
    idle(1);
    chk("R2 retire pc next", retire_pc, 32'h104);
    chk("R2 no flush", flush, 0);
    idle(4);
  endtask

  task automatic t_order;
    cyc(1, 32'h1FC, 0, 0, 0, 0, 1);          // older instruction Z
    cyc(1, 32'h200, 0, 0, 0, 0, 1);          // load A
    cyc(1, 32'h204, 0, 0, 0, 0, 1);
    cyc(1, 32'h208, 0, 0, 0, 0, 1);
    chk("R2 Z mem_wr_ok", mem_wr_ok, 1);
    cyc(1, 32'h20C, 2'd1, 0, 0, 2'd1, 1);    // A faults in MEM, D faults in IF
    chk("R7 faulting mem write blocked", mem_wr_ok, 0);
    chk("R9 older retires", rf_wr_ok, 1);
    chk("R9 older pc", retire_pc, 32'h1FC);
    cyc(1, 32'h999, 0, 0, 0, 0, 1);          // wrong-path fetch in flush cycle
    chk("R4 flush", flush, 1);
    chk("R5 epc older", epc, 32'h200);
    chk("R5 cause mem page", cause, 4'hD);
    chk("R4 redirect", rdr, TV);
    chk("R7 faulting no retire", rf_wr_ok, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk("R8 younger no retire", rf_wr_ok, 0);
      if (i == 0) chk("R4 flush one cycle", flush, 0);
    end
    cyc(1, TV, 0, 0, 0, 0, 1);
    idle(4);
    chk("R4 handler retires", rf_wr_ok, 1);
    chk("R4 handler pc", retire_pc, TV);
    idle(2);
  endtask

  task automatic t_young;
    cyc(1, 32'h300, 0, 0, 0, 0, 1);
    cyc(1, 32'h304, 0, 0, 0, 0, 1);
    cyc(1, 32'h308, 0, 2'd2, 2'd1, 0, 1);    // A arith in EX, B illegal in ID
    idle(1);
    chk("R7 faulted A no mem write", mem_wr_ok, 0);
    idle(1);
    chk("R4 flush young", flush, 1);
    chk("R5 epc A", epc, 32'h300);
    chk("R5 cause arith", cause, 4'h9);
    chk("R8 no retire flush cycle", rf_wr_ok, 0);
    idle(1);
    chk("R11 epc held", epc, 32'h300);
    chk("R11 cause held", cause, 4'h9);
    chk("R8 B no retire", rf_wr_ok, 0);
    idle(1);
    chk("R8 C no retire", rf_wr_ok, 0);
    idle(3);
  endtask

  task automatic t_multi;
    cyc(1, 32'h400, 2'd2, 0, 0, 0, 1);
    cyc(0, 0, 0, 2'd1, 0, 0, 1);
    cyc(0, 0, 0, 0, 2'd1, 0, 1);
    cyc(0, 0, 0, 0, 0, 2'd3, 1);
    idle(1);
    chk("R6 flush", flush, 1);
    chk("R6 epc", epc, 32'h400);
    chk("R6 earliest cause", cause, 4'h2);
    idle(3);
  endtask

  task automatic t_supp;
    cyc(1, 32'h500, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 2'd1, 0, 0, 1);
    idle(1);
    idle(1);
    chk("R7 id fault blocks mem write", mem_wr_ok, 0);
    idle(1);
    chk("R3 id undefined cause", cause, 4'h5);
    chk("R3 epc", epc, 32'h500);
    idle(3);
  endtask

  task automatic t_ignore;
    cyc(0, 0, 2'd3, 0, 0, 0, 1);
    cyc(0, 0, 0, 2'd1, 2'd1, 2'd2, 1);
    cyc(1, 32'h600, 0, 0, 0, 0, 1);
    idle(1);
    chk("R3 no flush", flush, 0);
    idle(1);
    chk("R3 no flush 2", flush, 0);
    idle(1);
    chk("R3 clean mem write", mem_wr_ok, 1);
    idle(1);
    chk("R3 clean retire", rf_wr_ok, 1);
    chk("R3 clean pc", retire_pc, 32'h600);
    chk("R11 cause kept", cause, 4'h5);
    idle(3);
  endtask

  task automatic t_stall;
    cyc(1, 32'h700, 0, 0, 0, 0, 1);
    idle(2);
    cyc(0, 0, 0, 0, 0, 2'd1, 0);
    chk("R10 stalled mem write", mem_wr_ok, 0);
    cyc(0, 0, 0, 0, 0, 2'd1, 0);
    chk("R10 no trap stalled", flush, 0);
    cyc(0, 0, 0, 0, 0, 2'd1, 1);
    chk("R10 no trap yet", flush, 0);
    idle(1);
    chk("R10 trap after release", flush, 1);
    chk("R10 epc", epc, 32'h700);
    chk("R10 cause", cause, 4'hD);
    idle(3);
  endtask

  initial begin
    rst_n = 1'b0;
    adv = 1'b1; ifv = 1'b0; ifpc = '0;
    fi = '0; fd = '0; fe = '0; fm = '0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_flow();
    t_order();
    t_young();
    t_multi();
    t_supp();
    t_ignore();
    t_stall();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule